// File: doc/BRIEF.md
# Posted / Non-Posted Transmit Packet Merger

This block sits in front of a transaction-layer transmit port. Two user packet sources feed it, one carrying posted requests and one carrying non-posted requests. It merges them onto one 128-bit beat stream. That stream has valid/ready flow control, start and end markers, and a 16-bit per-byte valid field. Packets are always whole multiples of 32 bits, so only the final beat of a packet may carry a partial byte-valid pattern.

The downstream core raises a credit flag while it can take another non-posted request. When the flag is low, no new non-posted packet may begin. A non-posted packet whose first beat has already been offered must still run to its end, even if the flag drops. Posted traffic is never held back by the flag, so posted packets bypass a blocked non-posted source.

The source is chosen only at a packet boundary, and the choice then holds until that packet's last beat is accepted. When both sources can start, they take turns. Beats pass through with no storage, so the block adds no cycles of latency.

Top module: `tlp_tx_merge`

## Requirements
- R1: After reset with no source valid, tx_valid is 0, and p_ready and np_ready are both 0.
- R2: The output beat (data, byte-valid, sop, eop) equals the beat of the granted source in the same cycle, including a partial final byte-valid pattern such as 16'h0FFF (12 bytes). The granted source's ready equals tx_ready, and the other source's ready is 0.
- R3: When no packet is in flight and np_credit_ok is 0, a non-posted start beat is not offered and np_ready stays 0. A posted start beat offered at the same time is forwarded.
- R4: Once a non-posted start beat has been offered, every remaining beat of that packet is forwarded, whatever the value of np_credit_ok.
- R5: Packets are never interleaved. From the cycle a source's start beat is offered until that source's eop beat is accepted, the other source's ready is 0 and its beats are not forwarded.
- R6: When both sources can start a packet, grants alternate between them. After reset the posted source wins the first such tie.
- R7: A start beat offered but not accepted (tx_ready low) stays granted in later cycles. This holds even if np_credit_ok falls or the other source becomes valid, because the credit flag is sampled only at the decision point.
- R8: Every output beat with tx_eop 0 has all 16 byte-valid bits set.
- R9: With no packet in flight, a source beat whose sop is 0 is not forwarded, and that source's ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_valid | input | 1 | Posted source beat valid |
| p_ready | output | 1 | Posted source beat accepted |
| p_sop | input | 1 | Posted beat is first of packet |
| p_eop | input | 1 | Posted beat is last of packet |
| p_data | input | 128 | Posted beat data |
| p_bytes | input | 16 | Posted per-byte valid |
| np_valid | input | 1 | Non-posted source beat valid |
| np_ready | output | 1 | Non-posted source beat accepted |
| np_sop | input | 1 | Non-posted beat is first of packet |
| np_eop | input | 1 | Non-posted beat is last of packet |
| np_data | input | 128 | Non-posted beat data |
| np_bytes | input | 16 | Non-posted per-byte valid |
| np_credit_ok | input | 1 | Core can take a new non-posted packet |
| tx_valid | output | 1 | Output beat valid |
| tx_ready | input | 1 | Core accepts output beat |
| tx_sop | output | 1 | Output beat is first of packet |
| tx_eop | output | 1 | Output beat is last of packet |
| tx_data | output | 128 | Output beat data |
| tx_bytes | output | 16 | Output per-byte valid |

## Verification
The bench first drops the credit flag in the middle of a three-beat non-posted packet. A design that re-checks the flag on every beat would cut the packet short. It then offers a posted start beat while that packet is still in flight. A design that re-arbitrates on every beat would interleave the two packets. Next, it stalls the output on a non-posted start beat and, during the stall, drops the flag and raises a posted start beat. A design that decides again during the stall would switch sources under a pending beat. Finally, it holds both sources valid for several packets in a row and checks that the winners alternate. It also checks that a valid beat without sop at idle is not forwarded.

// File: rtl/tlparb_pkg.sv
package tlparb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE    = 2'd0,
    OWN_POST    = 2'd1,
    OWN_NONPOST = 2'd2
  } owner_e;

  localparam int IDX_POST    = 0;
  localparam int IDX_NONPOST = 1;
  localparam int N_SRC       = 2;

endpackage

// File: rtl/tlparb_pick.sv
module tlparb_pick
  import tlparb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   post_elig_i,
  input  logic   np_elig_i,
  input  logic   commit_i,
  output owner_e pick_o
);

  // 1: the last granted packet was non-posted, so posted wins the next tie
  logic last_np_q;
  logic last_np_d;

  always_comb begin
    if (post_elig_i && np_elig_i) begin
      pick_o = last_np_q ? OWN_POST : OWN_NONPOST;
    end else if (post_elig_i) begin
      pick_o = OWN_POST;
    end else if (np_elig_i) begin
      pick_o = OWN_NONPOST;
    end else begin
      pick_o = OWN_NONE;
    end
  end

  always_comb begin
    last_np_d = last_np_q;
    if (commit_i) begin
      last_np_d = (pick_o == OWN_NONPOST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_np_q <= 1'b1;
    end else if (commit_i) begin
      last_np_q <= last_np_d;
    end
  end

  // R3
  no_blocked_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !np_elig_i |-> pick_o != OWN_NONPOST);

endmodule

// File: rtl/tlparb_mux.sv
module tlparb_mux
  import tlparb_pkg::*;
#(
  parameter int DATA_W = 128,
  localparam int BYTE_W = DATA_W / 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  owner_e                        route_i,
  input  logic [N_SRC-1:0]              src_valid_i,
  input  logic [N_SRC-1:0]              src_sop_i,
  input  logic [N_SRC-1:0]              src_eop_i,
  input  logic [N_SRC-1:0][DATA_W-1:0]  src_data_i,
  input  logic [N_SRC-1:0][BYTE_W-1:0]  src_bytes_i,
  output logic [N_SRC-1:0]              src_ready_o,
  input  logic                          out_ready_i,
  output logic                          out_valid_o,
  output logic                          out_sop_o,
  output logic                          out_eop_o,
  output logic [DATA_W-1:0]             out_data_o,
  output logic [BYTE_W-1:0]             out_bytes_o
);

  logic [N_SRC-1:0] hit;

  assign hit[IDX_POST]    = (route_i == OWN_POST);
  assign hit[IDX_NONPOST] = (route_i == OWN_NONPOST);

  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_ready
    assign src_ready_o[gi] = hit[gi] & out_ready_i;
  end

  always_comb begin
    out_valid_o = 1'b0;
    out_sop_o   = 1'b0;
    out_eop_o   = 1'b0;
    out_data_o  = '0;
    out_bytes_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (hit[i]) begin
        out_valid_o = src_valid_i[i];
        out_sop_o   = src_sop_i[i];
        out_eop_o   = src_eop_i[i];
        out_data_o  = src_data_i[i];
        out_bytes_o = src_bytes_i[i];
      end
    end
  end

  // R5
  single_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ready_o));

endmodule

// File: rtl/tlp_tx_merge.sv
module tlp_tx_merge
  import tlparb_pkg::*;
#(
  parameter int DATA_W = 128,
  localparam int BYTE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p_valid,
  output logic              p_ready,
  input  logic              p_sop,
  input  logic              p_eop,
  input  logic [DATA_W-1:0] p_data,
  input  logic [BYTE_W-1:0] p_bytes,
  input  logic              np_valid,
  output logic              np_ready,
  input  logic              np_sop,
  input  logic              np_eop,
  input  logic [DATA_W-1:0] np_data,
  input  logic [BYTE_W-1:0] np_bytes,
  input  logic              np_credit_ok,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic [DATA_W-1:0] tx_data,
  output logic [BYTE_W-1:0] tx_bytes
);

  owner_e owner_q, owner_d, pick, route;
  logic   idle, post_elig, np_elig, commit, accept;
  logic [N_SRC-1:0] ready_vec;

  assign idle      = (owner_q == OWN_NONE);
  assign post_elig = idle & p_valid & p_sop;
  assign np_elig   = idle & np_valid & np_sop & np_credit_ok;
  assign commit    = idle & (pick != OWN_NONE);
  assign route     = idle ? pick : owner_q;
  assign accept    = tx_valid & tx_ready;

  tlparb_pick u_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .post_elig_i (post_elig),
    .np_elig_i   (np_elig),
    .commit_i    (commit),
    .pick_o      (pick)
  );

  tlparb_mux #(.DATA_W(DATA_W)) u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .route_i     (route),
    .src_valid_i ({np_valid, p_valid}),
    .src_sop_i   ({np_sop, p_sop}),
    .src_eop_i   ({np_eop, p_eop}),
    .src_data_i  ({np_data, p_data}),
    .src_bytes_i ({np_bytes, p_bytes}),
    .src_ready_o (ready_vec),
    .out_ready_i (tx_ready),
    .out_valid_o (tx_valid),
    .out_sop_o   (tx_sop),
    .out_eop_o   (tx_eop),
    .out_data_o  (tx_data),
    .out_bytes_o (tx_bytes)
  );

  assign p_ready  = ready_vec[IDX_POST];
  assign np_ready = ready_vec[IDX_NONPOST];

  // grant locks at the first offer of a start beat, released by accepted eop
  always_comb begin
    owner_d = owner_q;
    if (accept && tx_eop) begin
      owner_d = OWN_NONE;
    end else if (idle) begin
      owner_d = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
    end else begin
      owner_q <= owner_d;
    end
  end

  // R5
  no_interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_POST) |-> !np_ready);

  // R4
  np_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_NONPOST) && np_valid |-> tx_valid && !p_ready);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> owner_q != OWN_NONE);

  // R8
  full_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_eop |-> &tx_bytes);

  // R9
  sop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle && tx_valid |-> tx_sop);

endmodule

// File: tb/test_tlp_tx_merge.sv
module test_tlp_tx_merge;

  logic         clk;
  logic         rst_n;
  logic         p_valid, p_ready, p_sop, p_eop;
  logic [127:0] p_data;
  logic [15:0]  p_bytes;
  logic         np_valid, np_ready, np_sop, np_eop;
  logic [127:0] np_data;
  logic [15:0]  np_bytes;
  logic         np_credit_ok;
  logic         tx_valid, tx_ready, tx_sop, tx_eop;
  logic [127:0] tx_data;
  logic [15:0]  tx_bytes;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  tlp_tx_merge i_tlp_tx_merge (
    .clk(clk), .rst_n(rst_n),
    .p_valid(p_valid), .p_ready(p_ready), .p_sop(p_sop), .p_eop(p_eop),
    .p_data(p_data), .p_bytes(p_bytes),
    .np_valid(np_valid), .np_ready(np_ready), .np_sop(np_sop), .np_eop(np_eop),
    .np_data(np_data), .np_bytes(np_bytes),
    .np_credit_ok(np_credit_ok),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .tx_data(tx_data), .tx_bytes(tx_bytes)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drv_p(input logic v, input logic s, input logic e,
                       input logic [127:0] d, input logic [15:0] b);
    p_valid = v; p_sop = s; p_eop = e; p_data = d; p_bytes = b;
  endtask

  task automatic drv_np(input logic v, input logic s, input logic e,
                        input logic [127:0] d, input logic [15:0] b);
    np_valid = v; np_sop = s; np_eop = e; np_data = d; np_bytes = b;
  endtask

  task automatic idle_all();
    @(negedge clk);
    drv_p(0, 0, 0, '0, '0);
    drv_np(0, 0, 0, '0, '0);
    np_credit_ok = 1'b1;
    tx_ready = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 p_ready", p_ready, 0);
    chk("R1 np_ready", np_ready, 0);
  endtask

  task automatic t_posted_partial();
    @(negedge clk);
    drv_p(1, 1, 1, 128'hA5A5_0001, 16'h0FFF);
    #1;
    chk("R2 tx_data", tx_data, 128'hA5A5_0001);
    chk("R2 tx_bytes", tx_bytes, 16'h0FFF);
    chk("R2 sop/eop", {tx_sop, tx_eop}, 2'b11);
    chk("R2 p_ready", p_ready, 1);
    chk("R2 np_ready", np_ready, 0);
    idle_all();
  endtask

  task automatic t_credit_block();
    @(negedge clk);
    np_credit_ok = 1'b0;
    drv_p(1, 1, 1, 128'hB0, 16'h00FF);
    drv_np(1, 1, 1, 128'hC0, 16'h000F);
    #1;
    chk("R3 posted passes", tx_data, 128'hB0);
    chk("R3 np_ready low", np_ready, 0);
    @(negedge clk);
    drv_p(0, 0, 0, '0, '0);
    #1;
    chk("R3 np blocked valid", tx_valid, 0);
    chk("R3 np blocked ready", np_ready, 0);
    idle_all();
  endtask

  task automatic t_np_in_flight();
    @(negedge clk);
    drv_np(1, 1, 0, 128'hD1, 16'hFFFF);
    #1;
    chk("R4 np beat1", tx_data, 128'hD1);
    @(negedge clk);
    np_credit_ok = 1'b0;
    drv_np(1, 0, 0, 128'hD2, 16'hFFFF);
    drv_p(1, 1, 1, 128'hE0, 16'hFFFF);
    #1;
    chk("R4 np beat2 after flag drop", tx_data, 128'hD2);
    chk("R4 np_ready", np_ready, 1);
    chk("R5 p_ready held off", p_ready, 0);
    @(negedge clk);
    drv_np(1, 0, 1, 128'hD3, 16'h000F);
    #1;
    chk("R4 np beat3", tx_data, 128'hD3);
    chk("R4 np last bytes", tx_bytes, 16'h000F);
    chk("R5 p_ready held off eop", p_ready, 0);
    @(negedge clk);
    drv_np(0, 0, 0, '0, '0);
    #1;
    chk("R5 posted after np eop", tx_data, 128'hE0);
    idle_all();
  endtask

  task automatic t_round_robin();
    // last winner so far is posted, so non-posted leads
    @(negedge clk);
    drv_p(1, 1, 1, 128'hF0, 16'hFFFF);
    drv_np(1, 1, 1, 128'hF1, 16'hFFFF);
    for (int k = 0; k < 4; k++) begin
      if (k != 0) @(negedge clk);
      #1;
      chk("R6 alternate", tx_data, (k % 2 == 0) ? 128'hF1 : 128'hF0);
    end
    idle_all();
  endtask

  task automatic t_stall_hold();
    @(negedge clk);
    tx_ready = 1'b0;
    drv_np(1, 1, 1, 128'h77, 16'hFFFF);
    #1;
    chk("R7 np offered", tx_data, 128'h77);
    chk("R7 np_ready low in stall", np_ready, 0);
    @(negedge clk);
    np_credit_ok = 1'b0;
    drv_p(1, 1, 1, 128'h88, 16'hFFFF);
    #1;
    chk("R7 grant held", tx_data, 128'h77);
    chk("R7 p_ready low", p_ready, 0);
    @(negedge clk);
    tx_ready = 1'b1;
    #1;
    chk("R7 np accepted", np_ready, 1);
    idle_all();
  endtask

  task automatic t_no_sop();
    @(negedge clk);
    drv_p(1, 0, 1, 128'h99, 16'hFFFF);
    #1;
    chk("R9 tx_valid", tx_valid, 0);
    chk("R9 p_ready", p_ready, 0);
    idle_all();
  endtask

  initial begin
    rst_n = 1'b0;
    drv_p(0, 0, 0, '0, '0);
    drv_np(0, 0, 0, '0, '0);
    np_credit_ok = 1'b1;
    tx_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_posted_partial();
    t_credit_block();
    t_np_in_flight();
    t_round_robin();
    t_stall_hold();
    t_no_sop();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule